// File: doc/BRIEF.md
# Page-Mode External Memory Bus Controller

This block runs the external memory bus cycles of an 8051-style core when the bus is configured for page mode. The core presents one request at a time (a code fetch, a data read or a data write) with a 16-bit address and, for writes, a byte. The block drives an address port and a data port, each split into separate out, output-enable and in signals. It also drives a high-active address-latch strobe and three active-low strobes for program store, read and write. When the cycle ends it returns a one-clock done pulse, with the byte that was read or fetched.

The block keeps the upper address byte of the last external access as the current page. An access to the same page is a hit. It is a short cycle in which only the low address byte goes out and the latch strobe stays quiet. Any other access is a miss. A miss first spends a half-cycle presenting the upper byte on the address port and pulsing the latch strobe, then runs exactly like a hit.

A 2-bit speed select sets the cycle lengths. Selects 0 to 2 share one bus arrangement: the address port carries both address bytes in turn and the data port is the data bus. Select 3 uses an alternate arrangement. In it, the data port carries the low address byte and the address port carries first the upper address byte and then the data byte.

Top module: `pgbus_ctrl`

## Requirements
- R1: An access is a miss when no page is stored or when its address bits 15:8 differ from the stored page; otherwise it is a hit. Each accepted access stores its bits 15:8 as the new page. The first access after reset is always a miss.
- R2: Requests are accepted only while `cfg_en` is 1 and the block is idle. For select 0, 1 and 2, the bus portion of the cycle lasts H clocks on a hit and 2H clocks on a miss, with H = 1, 2 and 4 respectively. `done_o` is high in the clock after the last bus clock.
- R3: For select 3, code fetches take 2 clocks on a hit and 4 on a miss. Data reads and writes always take 4 clocks. On a data hit, the first 2 clocks drive the upper address byte with the latch strobe low.
- R4: In the first half of a miss, the address port drives bits 15:8 and `ale_o` is 1. All three active-low strobes are high. In selects 0 to 2 the data port is not driven.
- R5: During the access half of any cycle (the whole of a hit), `ale_o` is 0. In selects 0 to 2 the address port drives bits 7:0.
- R6: During the access half of a fetch (`req_kind` = 0), `psen_n_o` is 0 and the data-carrying port is not driven. The byte on that port is captured at the clock edge where `psen_n_o` returns high, and it appears on `rdata_o` while `done_o` is 1.
- R7: During the access half of a read (`req_kind` = 1), `rd_n_o` is 0 and the data-carrying port is not driven; the byte is returned as in R6. During the access half of a write (`req_kind` = 2), `wr_n_o` is 0 and the data-carrying port drives `req_wdata`.
- R8: In select 3, the data port drives bits 7:0 for the whole bus portion. The address port carries the data byte during the access half. For selects 0 to 2, the data port is the data-carrying port.
- R9: Any change of `cfg_en` or `cfg_sel` discards the stored page, so the next access is a miss.
- R10: `done_o` is a single-clock pulse. At most one active-low strobe is low at any time. All strobes are inactive in the done clock and while idle.
- R11: During reset and while idle, all strobes are high, `ale_o` and `done_o` are 0, both ports are undriven and both port outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Page mode enable |
| cfg_sel | input | 2 | Speed / bus arrangement select |
| req_valid | input | 1 | Request held by the core until done |
| req_kind | input | 2 | 0 fetch, 1 read, 2 write |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write byte |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | 8 | Fetched or read byte, valid with done |
| addr_port_o | output | 8 | Address port output value |
| addr_port_oe | output | 1 | Address port drive enable |
| addr_port_i | input | 8 | Address port input value |
| data_port_o | output | 8 | Data port output value |
| data_port_oe | output | 1 | Data port drive enable |
| data_port_i | input | 8 | Data port input value |
| ale_o | output | 1 | Address latch strobe, active high |
| psen_n_o | output | 1 | Program-store strobe, active low |
| rd_n_o | output | 1 | Data read strobe, active low |
| wr_n_o | output | 1 | Data write strobe, active low |

## Verification
The hardest case to reach from the ports is a forced miss on an address whose upper byte matches the stored page. It only happens after a configuration change: toggling the enable, or moving to a new select, between two accesses to the same page. The stimulus makes exactly those changes and then repeats a page. A second case is a data hit under select 3, which still takes four clocks but keeps the latch strobe low. To reach it, the stimulus issues a fetch and then a read on the same page. The reference model tracks the page and the configuration on its own and predicts every port value in every clock.

// File: rtl/pgbus_pkg.sv
package pgbus_pkg;
  typedef enum logic [1:0] {
    KIND_FETCH = 2'd0,
    KIND_READ  = 2'd1,
    KIND_WRITE = 2'd2
  } kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_ACC  = 2'd2,
    ST_DONE = 2'd3
  } state_e;

  localparam logic [1:0] SEL_ALT = 2'd3;
  localparam int unsigned LEN_W  = 3;
endpackage

// File: rtl/pgbus_page_track.sv
module pgbus_page_track #(
  parameter int unsigned PG_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_en,
  input  logic [1:0]      cfg_sel,
  input  logic [PG_W-1:0] addr_hi,
  input  logic            take,
  output logic            miss
);
  logic [PG_W-1:0] page_q, page_d;
  logic            pvalid_q, pvalid_d;
  logic [2:0]      cfg_q;
  logic            cfg_chg;

  assign cfg_chg = ({cfg_en, cfg_sel} != cfg_q);
  assign miss    = !pvalid_q || cfg_chg || (addr_hi != page_q);

  always_comb begin
    page_d   = page_q;
    pvalid_d = pvalid_q;
    if (take) begin
      page_d   = addr_hi;
      pvalid_d = 1'b1;
    end else if (cfg_chg) begin
      pvalid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q   <= '0;
      pvalid_q <= 1'b0;
      cfg_q    <= '0;
    end else begin
      page_q   <= page_d;
      pvalid_q <= pvalid_d;
      cfg_q    <= {cfg_en, cfg_sel};
    end
  end

  // R9: a configuration change with no access in flight clears the stored page
  assert_cfg_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable({cfg_en, cfg_sel}) && !take) |=> !pvalid_q);
endmodule

// File: rtl/pgbus_timing.sv
module pgbus_timing
  import pgbus_pkg::*;
(
  input  logic [1:0]       sel,
  input  kind_e            kind,
  input  logic             miss,
  output logic [LEN_W-1:0] first_len,
  output logic [LEN_W-1:0] acc_len
);
  logic is_alt_data;

  always_comb begin
    unique case (sel)
      2'd0:    acc_len = LEN_W'(1);
      2'd1:    acc_len = LEN_W'(2);
      2'd2:    acc_len = LEN_W'(4);
      default: acc_len = LEN_W'(2);
    endcase
  end

  assign is_alt_data = (sel == SEL_ALT) && (kind != KIND_FETCH);
  assign first_len   = (miss || is_alt_data) ? acc_len : '0;
endmodule

// File: rtl/pgbus_seq.sv
module pgbus_seq
  import pgbus_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [1:0]        sel,
  input  kind_e             kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              miss,
  input  logic [LEN_W-1:0]  first_len,
  input  logic [LEN_W-1:0]  acc_len,
  output logic              accept,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] addr_port_o,
  output logic              addr_port_oe,
  input  logic [DATA_W-1:0] addr_port_i,
  output logic [DATA_W-1:0] data_port_o,
  output logic              data_port_oe,
  input  logic [DATA_W-1:0] data_port_i,
  output logic              ale_o,
  output logic              psen_n_o,
  output logic              rd_n_o,
  output logic              wr_n_o
);
  state_e             st_q, st_d;
  logic [LEN_W-1:0]   cnt_q, cnt_d, hlen_q, hlen_d;
  kind_e              kind_q, kind_d;
  logic               alt_q, alt_d, miss_q, miss_d;
  logic [ADDR_W-1:0]  addr_q, addr_d;
  logic [DATA_W-1:0]  wd_q, wd_d;
  logic               cap;
  logic               ale_d, psen_d, rd_d, wr_d, aoe_d, doe_d, done_d;
  logic [DATA_W-1:0]  ao_d, do_d, lo_d, hi_d;

  assign accept = (st_q == ST_IDLE) && go;

  // next state
  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    hlen_d = hlen_q;
    kind_d = kind_q;
    alt_d  = alt_q;
    miss_d = miss_q;
    addr_d = addr_q;
    wd_d   = wd_q;
    cap    = 1'b0;
    unique case (st_q)
      ST_IDLE: if (accept) begin
        kind_d = kind;
        alt_d  = (sel == SEL_ALT);
        miss_d = miss;
        hlen_d = acc_len;
        addr_d = addr;
        wd_d   = wdata;
        if (first_len != '0) begin
          st_d  = ST_ADDR;
          cnt_d = first_len - LEN_W'(1);
        end else begin
          st_d  = ST_ACC;
          cnt_d = acc_len - LEN_W'(1);
        end
      end
      ST_ADDR: if (cnt_q == '0) begin
        st_d  = ST_ACC;
        cnt_d = hlen_q - LEN_W'(1);
      end else begin
        cnt_d = cnt_q - LEN_W'(1);
      end
      ST_ACC: if (cnt_q == '0) begin
        st_d = ST_DONE;
        cap  = 1'b1;
      end else begin
        cnt_d = cnt_q - LEN_W'(1);
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // next bus outputs, derived from the next state so they leave registers
  always_comb begin
    lo_d   = addr_d[DATA_W-1:0];
    hi_d   = addr_d[ADDR_W-1:DATA_W];
    ale_d  = (st_d == ST_ADDR) && miss_d;
    psen_d = !((st_d == ST_ACC) && (kind_d == KIND_FETCH));
    rd_d   = !((st_d == ST_ACC) && (kind_d == KIND_READ));
    wr_d   = !((st_d == ST_ACC) && (kind_d == KIND_WRITE));
    done_d = (st_d == ST_DONE);
    aoe_d  = 1'b0;
    ao_d   = '0;
    doe_d  = 1'b0;
    do_d   = '0;
    if (st_d == ST_ADDR) begin
      aoe_d = 1'b1;
      ao_d  = hi_d;
      if (alt_d) begin
        doe_d = 1'b1;
        do_d  = lo_d;
      end
    end else if (st_d == ST_ACC) begin
      if (alt_d) begin
        doe_d = 1'b1;
        do_d  = lo_d;
        aoe_d = (kind_d == KIND_WRITE);
        ao_d  = (kind_d == KIND_WRITE) ? wd_d : '0;
      end else begin
        aoe_d = 1'b1;
        ao_d  = lo_d;
        doe_d = (kind_d == KIND_WRITE);
        do_d  = (kind_d == KIND_WRITE) ? wd_d : '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      hlen_q <= '0;
      kind_q <= KIND_FETCH;
      alt_q  <= 1'b0;
      miss_q <= 1'b0;
      addr_q <= '0;
      wd_q   <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      hlen_q <= hlen_d;
      kind_q <= kind_d;
      alt_q  <= alt_d;
      miss_q <= miss_d;
      addr_q <= addr_d;
      wd_q   <= wd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_o        <= 1'b0;
      psen_n_o     <= 1'b1;
      rd_n_o       <= 1'b1;
      wr_n_o       <= 1'b1;
      done_o       <= 1'b0;
      addr_port_oe <= 1'b0;
      addr_port_o  <= '0;
      data_port_oe <= 1'b0;
      data_port_o  <= '0;
    end else begin
      ale_o        <= ale_d;
      psen_n_o     <= psen_d;
      rd_n_o       <= rd_d;
      wr_n_o       <= wr_d;
      done_o       <= done_d;
      addr_port_oe <= aoe_d;
      addr_port_o  <= ao_d;
      data_port_oe <= doe_d;
      data_port_o  <= do_d;
    end
  end

  // capture register with an explicit enable at the strobe release edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_o <= '0;
    end else if (cap) begin
      rdata_o <= alt_q ? addr_port_i : data_port_i;
    end
  end

  assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~psen_n_o, ~rd_n_o, ~wr_n_o}) <= 1);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_ale_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ale_o |-> (psen_n_o && rd_n_o && wr_n_o && (alt_q || !data_port_oe)));

  assert_acc_noale_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ACC) |-> !ale_o);
endmodule

// File: rtl/pgbus_ctrl.sv
module pgbus_ctrl
  import pgbus_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic [1:0]        cfg_sel,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] addr_port_o,
  output logic              addr_port_oe,
  input  logic [DATA_W-1:0] addr_port_i,
  output logic [DATA_W-1:0] data_port_o,
  output logic              data_port_oe,
  input  logic [DATA_W-1:0] data_port_i,
  output logic              ale_o,
  output logic              psen_n_o,
  output logic              rd_n_o,
  output logic              wr_n_o
);
  logic             rs_meta, rs_n;
  logic             miss, accept;
  logic [LEN_W-1:0] first_len, acc_len;
  kind_e            kind;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_n    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_n    <= rs_meta;
    end
  end

  assign kind = kind_e'(req_kind);

  pgbus_page_track #(.PG_W(DATA_W)) u_page (
    .clk     (clk),
    .rst_n   (rs_n),
    .cfg_en  (cfg_en),
    .cfg_sel (cfg_sel),
    .addr_hi (req_addr[ADDR_W-1:DATA_W]),
    .take    (accept),
    .miss    (miss)
  );

  pgbus_timing u_timing (
    .sel       (cfg_sel),
    .kind      (kind),
    .miss      (miss),
    .first_len (first_len),
    .acc_len   (acc_len)
  );

  pgbus_seq #(.DATA_W(DATA_W)) u_seq (
    .clk          (clk),
    .rst_n        (rs_n),
    .go           (req_valid && cfg_en),
    .sel          (cfg_sel),
    .kind         (kind),
    .addr         (req_addr),
    .wdata        (req_wdata),
    .miss         (miss),
    .first_len    (first_len),
    .acc_len      (acc_len),
    .accept       (accept),
    .done_o       (done_o),
    .rdata_o      (rdata_o),
    .addr_port_o  (addr_port_o),
    .addr_port_oe (addr_port_oe),
    .addr_port_i  (addr_port_i),
    .data_port_o  (data_port_o),
    .data_port_oe (data_port_oe),
    .data_port_i  (data_port_i),
    .ale_o        (ale_o),
    .psen_n_o     (psen_n_o),
    .rd_n_o       (rd_n_o),
    .wr_n_o       (wr_n_o)
  );
endmodule

// File: tb/tb_pgbus_ctrl.sv
`timescale 1ns/1ps
module tb_pgbus_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_en = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'd0;
  logic [15:0] req_addr = 16'h0;
  logic [7:0]  req_wdata = 8'h0;
  logic [7:0]  addr_port_i = 8'h0;
  logic [7:0]  data_port_i = 8'h0;
  logic        done_o, addr_port_oe, data_port_oe, ale_o, psen_n_o, rd_n_o, wr_n_o;
  logic [7:0]  rdata_o, addr_port_o, data_port_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit finished = 1'b0;

  // reference model state
  bit       m_pv = 1'b0;
  bit [7:0] m_pg = 8'h0;

  always #4 clk = ~clk;

  pgbus_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_sel(cfg_sel),
    .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
    .req_wdata(req_wdata), .done_o(done_o), .rdata_o(rdata_o),
    .addr_port_o(addr_port_o), .addr_port_oe(addr_port_oe), .addr_port_i(addr_port_i),
    .data_port_o(data_port_o), .data_port_oe(data_port_oe), .data_port_i(data_port_i),
    .ale_o(ale_o), .psen_n_o(psen_n_o), .rd_n_o(rd_n_o), .wr_n_o(wr_n_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !finished) begin
      finished = 1'b1;
      n_fail++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic expect_bus(string tag, bit dn, bit ale, bit ps, bit rd, bit wr,
                            bit aoe, bit [7:0] ao, bit doe, bit [7:0] dout);
    logic [22:0] act, exp;
    act = {done_o, ale_o, psen_n_o, rd_n_o, wr_n_o, addr_port_oe, data_port_oe,
           addr_port_o, data_port_o};
    exp = {dn, ale, ps, rd, wr, aoe, doe, ao, dout};
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic expect_idle(string tag);
    expect_bus(tag, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h0, 1'b0, 8'h0);
  endtask

  task automatic set_cfg(bit en, bit [1:0] sel);
    @(negedge clk);
    if (en != cfg_en || sel != cfg_sel) m_pv = 1'b0; // R9
    cfg_en  = en;
    cfg_sel = sel;
  endtask

  // kind: 0 fetch, 1 read, 2 write
  task automatic do_acc(bit [1:0] kind, bit [15:0] addr, bit [7:0] wd, bit [7:0] busb);
    int  h, f;
    bit  alt, miss;
    bit [7:0] hi, lo;
    string tg;
    h    = (cfg_sel == 2'd0) ? 1 : (cfg_sel == 2'd1) ? 2 : (cfg_sel == 2'd2) ? 4 : 2;
    alt  = (cfg_sel == 2'd3);
    miss = !m_pv || (m_pg != addr[15:8]);          // R1
    f    = (miss || (alt && kind != 2'd0)) ? h : 0; // R2 R3 lengths
    hi   = addr[15:8];
    lo   = addr[7:0];
    m_pg = hi;
    m_pv = 1'b1;
    @(negedge clk);
    req_valid   = 1'b1;
    req_kind    = kind;
    req_addr    = addr;
    req_wdata   = wd;
    addr_port_i = busb;
    data_port_i = busb;
    for (int k = 0; k < f; k++) begin
      @(negedge clk);
      tg = alt ? "R3 R8 first half" : (miss ? "R2 R4 R1 miss first half" : "R2 R4");
      expect_bus(tg, 1'b0, miss, 1'b1, 1'b1, 1'b1, 1'b1, hi, alt, alt ? lo : 8'h0);
    end
    for (int k = 0; k < h; k++) begin
      @(negedge clk);
      tg = (kind == 2'd0) ? "R6 R5 access half" : "R7 R5 access half";
      if (alt) begin
        tg = {tg, " R8 R3"};
        expect_bus(tg, 1'b0, 1'b0, kind != 2'd0, kind != 2'd1, kind != 2'd2,
                   kind == 2'd2, (kind == 2'd2) ? wd : 8'h0, 1'b1, lo);
      end else begin
        tg = {tg, " R2"};
        expect_bus(tg, 1'b0, 1'b0, kind != 2'd0, kind != 2'd1, kind != 2'd2,
                   1'b1, lo, kind == 2'd2, (kind == 2'd2) ? wd : 8'h0);
      end
    end
    @(negedge clk);
    expect_bus("R10 R2 R3 done clock", 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h0, 1'b0, 8'h0);
    if (kind != 2'd2) begin
      n_tests++;
      if (rdata_o !== busb) begin
        n_fail++;
        $display("FAIL R6 R7 rdata: act=%h exp=%h", rdata_o, busb);
      end
    end
    req_valid = 1'b0;
    @(negedge clk);
    expect_idle("R10 R11 idle after done");
  endtask

  initial begin
    // R11 reset state
    repeat (3) @(negedge clk);
    expect_idle("R11 in reset");
    n_tests++;
    if (rdata_o !== 8'h0) begin
      n_fail++;
      $display("FAIL R11 rdata: act=%h exp=00", rdata_o);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    expect_idle("R11 after release");

    // request while disabled is not taken (R2)
    req_valid = 1'b1;
    req_addr  = 16'h4321;
    repeat (3) @(negedge clk);
    expect_idle("R2 disabled no cycle");
    req_valid = 1'b0;

    // select 0
    set_cfg(1'b1, 2'd0);
    do_acc(2'd0, 16'h1234, 8'h00, 8'hA5); // R1 first access miss
    do_acc(2'd0, 16'h1256, 8'h00, 8'h5A); // R5 hit
    do_acc(2'd1, 16'h12AA, 8'h00, 8'h3C); // read hit
    do_acc(2'd2, 16'h3300, 8'hC3, 8'h00); // write miss
    do_acc(2'd2, 16'h3301, 8'h96, 8'h00); // write hit
    // select 1: same page, forced miss (R9)
    set_cfg(1'b1, 2'd1);
    do_acc(2'd0, 16'h3310, 8'h00, 8'h11);
    do_acc(2'd0, 16'h3311, 8'h00, 8'h22);
    do_acc(2'd1, 16'h7F00, 8'h00, 8'h33);
    // select 2
    set_cfg(1'b1, 2'd2);
    do_acc(2'd1, 16'h7F01, 8'h00, 8'h44);
    do_acc(2'd0, 16'h7F02, 8'h00, 8'h55);
    do_acc(2'd2, 16'h7F03, 8'h77, 8'h00);
    do_acc(2'd0, 16'hFF03, 8'h00, 8'h66);
    // select 3 alternate arrangement
    set_cfg(1'b1, 2'd3);
    do_acc(2'd0, 16'h2040, 8'h00, 8'h81); // fetch miss 4
    do_acc(2'd0, 16'h2041, 8'h00, 8'h82); // fetch hit 2
    do_acc(2'd1, 16'h2042, 8'h00, 8'h83); // data hit still 4, no ale
    do_acc(2'd2, 16'h5042, 8'hE7, 8'h00); // write miss
    do_acc(2'd2, 16'h5043, 8'h18, 8'h00); // write hit
    // R9 enable toggle on same page
    set_cfg(1'b0, 2'd3);
    set_cfg(1'b1, 2'd3);
    do_acc(2'd0, 16'h5044, 8'h00, 8'h99);
    set_cfg(1'b1, 2'd0);
    do_acc(2'd1, 16'h5045, 8'h00, 8'hAA);
    do_acc(2'd1, 16'h5046, 8'h00, 8'hBB);

    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule